// File: doc/BRIEF.md
# Memory-Write Interrupt Controller

This block gathers level-sensitive interrupt requests from up to 32 peripheral source lines of an I/O companion chip and hands them to the processor. A source line that is high is always recorded in a pending register. If that source is also enabled in the mask, it is recorded in a request register. The controller does not drive an interrupt wire. It signals the processor with a single 32-bit bus-master memory write, and both the target address and the written data come from one programmable vector register.

Software reaches the block through a simple register port that takes word accesses with per-byte write enables. The delivery port is a valid/ready write request carrying an address and a data word. Only one delivery write is in flight at a time. Enabled requests that arrive while a write is stalled are remembered per source and issued once the current write completes. A bus-error flag in the control register suppresses delivery.

Fixed source positions: serial 5, parallel 7, network 8, disk 9, audio 13, the chip's own events 14, the two PS/2 ports together on 26. Bits 16 to 21 are also enableable.

Top module: `mwi_irq_ctrl`

## Requirements
- R1: After reset the request, mask, pending and control registers read zero, the vector register reads the IAR_RST parameter, and mw_valid is low.
- R2: Every cycle in which source line i is high sets pending bit i (word index 2), whether or not mask bit i is set.
- R3: A read of word index 2 returns the pending value and clears it on that clock edge. A write to word index 2 clears it whatever the data. A source line high in the clearing cycle leaves its bit set.
- R4: Request bit i (word index 0, read-only) becomes set in any cycle in which source line i is high and mask bit i is set. It stays set until reset. Writes to word index 0 change nothing.
- R5: Mask (word index 1) stores only bits 5, 7, 8, 9, 13, 14, 16 to 21 and 26. Every other bit is discarded on write and reads back zero.
- R6: A rising edge of (source AND mask) while the bus-error bit is clear schedules one delivery write. mw_valid rises on the edge after it is launched. mw_addr is the vector register with bits 4:0 cleared. mw_data is vector bits 4:0 zero-extended to 32 bits, where mw_data[31:24] is the byte at the lowest address (big-endian), so the five bits sit in mw_data[4:0].
- R7: Control (word index 3) keeps only bit 8, the bus-error flag, which is written from wdata[8] when reg_be[1] is set. A read returns bit 8 with all other bits zero.
- R8: No delivery write is launched while the bus-error bit is set. Rising edges that occur during that time are discarded. Writes queued earlier wait until the bit clears.
- R9: Once mw_valid is high it stays high, with mw_addr and mw_data unchanged, until a cycle with mw_ready high. Enabled rising edges during that time are held, one per source, and are issued one write at a time after completion, lowest source first.
- R10: Writes to mask, control and vector (word index 4) update only the bytes whose reg_be bit is set, where reg_be[k] covers wdata[8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_widx | input | 3 | Word index (byte offset / 4): 0 request, 1 mask, 2 pending, 3 control, 4 vector |
| reg_be | input | 4 | Byte write enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read access |
| irq_in | input | NSRC | Level interrupt source lines |
| mw_valid | output | 1 | Delivery write request |
| mw_addr | output | 32 | Delivery write address (32-byte aligned) |
| mw_data | output | 32 | Delivery write data |
| mw_ready | input | 1 | Fabric accepts the delivery write |

## Verification
Two functions can fall on the same edge: the clear of the pending register caused by a read or write of word index 2, and the setting of pending bits by source lines that are high. The bench reads pending while it holds a source high in that same cycle, then reads again and expects the bit to have survived the clear. A second collision is a new enabled edge arriving while a delivery write is stalled, or while the bus-error bit is being set. These are provoked by holding mw_ready low across source edges. A behavioural model decides on every cycle whether each edge must produce a write, be held, or be dropped.

// File: rtl/mwi_pkg.sv
// Shared constants, register word map and helpers for the memory-write
// interrupt controller. Assumes 32-bit register words with byte enables.
package mwi_pkg;

    localparam int WORD_W   = 32;
    localparam int BE_W     = WORD_W / 8;
    localparam int RIDX_W   = 3;
    localparam int SLOT_W   = 5;   // delivery address alignment / data bits
    localparam int BERR_BIT = 8;   // bus-error flag position in control

    // Register words, addressed by word index
    typedef enum logic [RIDX_W-1:0] {
        W_REQ  = 3'd0,
        W_MASK = 3'd1,
        W_PEND = 3'd2,
        W_CTRL = 3'd3,
        W_VEC  = 3'd4
    } reg_word_e;

    // Fixed source positions
    localparam int SRC_SERIAL   = 5;
    localparam int SRC_PARALLEL = 7;
    localparam int SRC_NET      = 8;
    localparam int SRC_DISK     = 9;
    localparam int SRC_AUDIO    = 13;
    localparam int SRC_SELF     = 14;
    localparam int SRC_PS2      = 26;

    localparam logic [WORD_W-1:0] LEGAL_SRC =
        (WORD_W'(1) << SRC_SERIAL) | (WORD_W'(1) << SRC_PARALLEL) |
        (WORD_W'(1) << SRC_NET)    | (WORD_W'(1) << SRC_DISK)     |
        (WORD_W'(1) << SRC_AUDIO)  | (WORD_W'(1) << SRC_SELF)     |
        (WORD_W'(1) << SRC_PS2)    | (WORD_W'(32'h3F) << 16);

    // Replace the bytes of old_v selected by be with those of new_v
    function automatic logic [WORD_W-1:0] byte_merge(
        input logic [WORD_W-1:0] old_v,
        input logic [WORD_W-1:0] new_v,
        input logic [BE_W-1:0]   be
    );
        logic [WORD_W-1:0] r;
        r = old_v;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/mwi_regfile.sv
// Software-visible registers: mask, bus-error flag and delivery vector, plus
// the read multiplexer. Reads are combinational in the access cycle; the
// pending clear strobe goes to the capture stage for the same edge.
// Assumes reg_widx is a word index and byte enables apply to writes only.
module mwi_regfile
    import mwi_pkg::*;
#(
    parameter int                NSRC    = 32,
    parameter logic [WORD_W-1:0] IAR_RST = 32'h0000_0003,
    parameter logic [WORD_W-1:0] LEGAL   = LEGAL_SRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_widx,
    input  logic [BE_W-1:0]   reg_be,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]   pend,
    input  logic [NSRC-1:0]   req,
    output logic [NSRC-1:0]   mask,
    output logic              berr,
    output logic [WORD_W-1:0] vec,
    output logic              pend_clr
);

    localparam logic [WORD_W-1:0] SRC_SPAN = {WORD_W{1'b1}} >> (WORD_W - NSRC);
    localparam logic [WORD_W-1:0] KEEP     = LEGAL & SRC_SPAN;

    logic [WORD_W-1:0] mask_w;
    logic [WORD_W-1:0] vec_q;
    logic              berr_q;
    reg_word_e         word;
    logic              wr_en;

    assign word     = reg_word_e'(reg_widx);
    assign wr_en    = reg_sel && reg_we;
    assign pend_clr = reg_sel && (word == W_PEND);
    assign mask     = mask_w[NSRC-1:0];
    assign berr     = berr_q;
    assign vec      = vec_q;

    // Register writes with byte enables; request word is read-only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_w <= '0;
            berr_q <= 1'b0;
            vec_q  <= IAR_RST;
        end else if (wr_en) begin
            case (word)
                W_MASK:  mask_w <= byte_merge(mask_w, reg_wdata, reg_be) & KEEP;
                W_CTRL:  if (reg_be[BERR_BIT/8]) berr_q <= reg_wdata[BERR_BIT];
                W_VEC:   vec_q  <= byte_merge(vec_q, reg_wdata, reg_be);
                default: ;
            endcase
        end
    end

    // Read multiplexer, zero for unmapped words and for writes
    always_comb begin
        reg_rdata = '0;
        if (reg_sel && !reg_we) begin
            case (word)
                W_REQ:   reg_rdata = WORD_W'(req);
                W_MASK:  reg_rdata = mask_w;
                W_PEND:  reg_rdata = WORD_W'(pend);
                W_CTRL:  reg_rdata[BERR_BIT] = berr_q;
                W_VEC:   reg_rdata = vec_q;
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mwi_capture.sv
// Per-source capture: pending (any high level), request (high and enabled),
// enabled-edge detection and the per-source "write owed" flags. The
// delivery stage takes owed flags lowest source first through 'take'.
// Assumes source lines are synchronous to clk.
module mwi_capture #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic [NSRC-1:0] mask,
    input  logic            berr,
    input  logic            pend_clr,
    input  logic            take,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] req,
    output logic            owe_any
);

    logic [NSRC-1:0] en_now;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] fire;
    logic [NSRC-1:0] owe;
    logic [NSRC-1:0] lowest;

    assign en_now  = irq_in & mask;
    assign fire    = en_now & ~en_q;
    assign lowest  = owe & (~owe + NSRC'(1));
    assign owe_any = |owe;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // One source slice: pending, request, edge history and owed write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
                req[i]  <= 1'b0;
                en_q[i] <= 1'b0;
                owe[i]  <= 1'b0;
            end else begin
                pend[i] <= irq_in[i] | (pend[i] & ~pend_clr);
                if (en_now[i]) req[i] <= 1'b1;
                en_q[i] <= en_now[i];
                owe[i]  <= (owe[i] & ~(take & lowest[i])) | (fire[i] & ~berr);
            end
        end
    end

    // R2: a high source line is in pending on the next cycle
    a_r2_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend & $past(irq_in)) == $past(irq_in)));

    // R3: after a clear only the lines high in the clearing cycle remain
    a_r3_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pend_clr) |=> (pend == $past(irq_in)));

    // R4: enabled high lines are recorded in request
    a_r4_req_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((req & $past(irq_in & mask)) == $past(irq_in & mask)));

endmodule

// File: rtl/mwi_deliver.sv
// Delivery write master: launches one aligned write when a write is owed,
// no write is in flight and the bus-error flag is clear; holds it until
// mw_ready. Address and data are captured from the vector at launch.
module mwi_deliver
    import mwi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              owe_any,
    input  logic              berr,
    input  logic [WORD_W-1:0] vec,
    input  logic              mw_ready,
    output logic              take,
    output logic              mw_valid,
    output logic [WORD_W-1:0] mw_addr,
    output logic [WORD_W-1:0] mw_data
);

    assign take = !mw_valid && owe_any && !berr;

    // Launch, hold and retire the single outstanding write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mw_valid <= 1'b0;
            mw_addr  <= '0;
            mw_data  <= '0;
        end else if (take) begin
            mw_valid <= 1'b1;
            mw_addr  <= {vec[WORD_W-1:SLOT_W], SLOT_W'(0)};
            mw_data  <= WORD_W'(vec[SLOT_W-1:0]);
        end else if (mw_valid && mw_ready) begin
            mw_valid <= 1'b0;
        end
    end

    // R9: a stalled write keeps its request and payload
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

    // R6: delivery address is 32-byte aligned
    a_r6_align: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid |-> (mw_addr[SLOT_W-1:0] == '0));

    // R8: no write starts while the bus-error flag was set
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_valid) |-> !$past(berr));

endmodule

// File: rtl/mwi_irq_ctrl.sv
// Memory-write interrupt controller top: register file, per-source capture
// and delivery master. Assumes a single clock domain and synchronous sources.
module mwi_irq_ctrl
    import mwi_pkg::*;
#(
    parameter int                NSRC    = 32,
    parameter logic [WORD_W-1:0] IAR_RST = 32'hFFFE_0003,
    parameter logic [WORD_W-1:0] LEGAL   = LEGAL_SRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_widx,
    input  logic [BE_W-1:0]   reg_be,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]   irq_in,
    output logic              mw_valid,
    output logic [WORD_W-1:0] mw_addr,
    output logic [WORD_W-1:0] mw_data,
    input  logic              mw_ready
);

    logic [NSRC-1:0]   pend;
    logic [NSRC-1:0]   req;
    logic [NSRC-1:0]   mask;
    logic              berr;
    logic [WORD_W-1:0] vec;
    logic              pend_clr;
    logic              take;
    logic              owe_any;

    mwi_regfile #(
        .NSRC    (NSRC),
        .IAR_RST (IAR_RST),
        .LEGAL   (LEGAL)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_widx  (reg_widx),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pend      (pend),
        .req       (req),
        .mask      (mask),
        .berr      (berr),
        .vec       (vec),
        .pend_clr  (pend_clr)
    );

    mwi_capture #(
        .NSRC (NSRC)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .mask     (mask),
        .berr     (berr),
        .pend_clr (pend_clr),
        .take     (take),
        .pend     (pend),
        .req      (req),
        .owe_any  (owe_any)
    );

    mwi_deliver u_dlv (
        .clk      (clk),
        .rst_n    (rst_n),
        .owe_any  (owe_any),
        .berr     (berr),
        .vec      (vec),
        .mw_ready (mw_ready),
        .take     (take),
        .mw_valid (mw_valid),
        .mw_addr  (mw_addr),
        .mw_data  (mw_data)
    );

endmodule

// File: tb/sim_mwi_irq_ctrl.sv
// Bench: behavioural reference model updated on every rising edge and
// compared with the delivery port on every falling edge; register reads
// are compared in the access cycle.
module sim_mwi_irq_ctrl;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] TB_IAR     = 32'h1234_5687;
    localparam logic [31:0] TB_LEGAL   = 32'h043F_63A0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  widx = 3'd0;
    logic [3:0]  be = 4'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] irq = 32'h0;
    logic        mw_ready = 1'b1;
    logic [31:0] rdata;
    logic        mw_valid;
    logic [31:0] mw_addr;
    logic [31:0] mw_data;

    int checks = 0;
    int errors = 0;

    // Reference state
    logic [31:0] m_pend = 0, m_req = 0, m_mask = 0, m_iar = TB_IAR;
    logic [31:0] m_owe = 0, m_enq = 0, m_addr = 0, m_data = 0;
    logic        m_berr = 0, m_valid = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mwi_irq_ctrl #(.NSRC(32), .IAR_RST(TB_IAR)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (sel),
        .reg_we    (we),
        .reg_widx  (widx),
        .reg_be    (be),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_in    (irq),
        .mw_valid  (mw_valid),
        .mw_addr   (mw_addr),
        .mw_data   (mw_data),
        .mw_ready  (mw_ready)
    );

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] b);
        logic [31:0] r;
        r = o;
        for (int k = 0; k < 4; k++) if (b[k]) r[8*k +: 8] = n[8*k +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [2:0] idx);
        case (idx)
            3'd0: return m_req;
            3'd1: return m_mask;
            3'd2: return m_pend;
            3'd3: return {23'h0, m_berr, 8'h0};
            3'd4: return m_iar;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model: next state from the requirements
    always @(posedge clk) begin : ref_model
        logic [31:0] en, fire, nxt;
        if (!rst_n) begin
            m_pend = 0; m_req = 0; m_mask = 0; m_berr = 0; m_iar = TB_IAR;
            m_owe = 0; m_enq = 0; m_valid = 0; m_addr = 0; m_data = 0;
        end else begin
            en   = irq & m_mask;
            fire = en & ~m_enq;
            nxt  = m_owe;
            if (!m_valid && m_owe != 0 && !m_berr) begin
                for (int i = 0; i < 32; i++) if (nxt[i]) begin nxt[i] = 1'b0; break; end
                m_valid = 1'b1;
                m_addr  = m_iar & 32'hFFFF_FFE0;
                m_data  = m_iar & 32'h0000_001F;
            end else if (m_valid && mw_ready) begin
                m_valid = 1'b0;
            end
            if (!m_berr) nxt = nxt | fire;
            m_owe  = nxt;
            m_enq  = en;
            m_req  = m_req | en;
            m_pend = ((sel && widx == 3'd2) ? 32'h0 : m_pend) | irq;
            if (sel && we) begin
                case (widx)
                    3'd1: m_mask = merge(m_mask, wdata, be) & TB_LEGAL;
                    3'd3: if (be[1]) m_berr = wdata[8];
                    3'd4: m_iar = merge(m_iar, wdata, be);
                    default: ;
                endcase
            end
        end
    end

    // Delivery port compared every cycle (R6 payload, R8 and R9 timing)
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9/R8", "mw_valid", {31'h0, mw_valid}, {31'h0, m_valid});
            if (m_valid) begin
                chk("R6", "mw_addr", mw_addr, m_addr);
                chk("R6", "mw_data", mw_data, m_data);
            end
        end
    end

    task automatic rd(input logic [2:0] idx, input string tag);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; widx = idx; be = 4'hF;
        #1 chk(tag, "reg read", rdata, exp_rd(idx));
    endtask

    task automatic wr(input logic [2:0] idx, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; widx = idx; be = b; wdata = d;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            sel = 1'b0; we = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(3'd0, "R1"); rd(3'd1, "R1"); rd(3'd2, "R1"); rd(3'd3, "R1"); rd(3'd4, "R1");
        chk("R1", "vector reset", exp_rd(3'd4), TB_IAR);
        // R4 request word ignores writes
        wr(3'd0, 4'hF, 32'hFFFF_FFFF); rd(3'd0, "R4");
        // R5 only legal mask bits; R10 byte enables
        wr(3'd1, 4'hF, 32'hFFFF_FFFF); rd(3'd1, "R5");
        chk("R5", "legal mask", rdata, 32'h043F_63A0);
        wr(3'd1, 4'h1, 32'h0); rd(3'd1, "R10");
        wr(3'd1, 4'hF, 32'h0400_0120); rd(3'd1, "R5");
        // R2 unmasked source sets pending only
        irq = 32'h0000_0008; idle(2); irq = 32'h0; idle(1);
        rd(3'd2, "R2"); rd(3'd0, "R4");
        // R3 read clears; same-cycle source keeps its bit
        rd(3'd2, "R3");
        irq = 32'h0000_0008; idle(1);
        rd(3'd2, "R3"); rd(3'd2, "R3");
        irq = 32'h0; wr(3'd2, 4'hF, 32'h0); rd(3'd2, "R3");
        irq = 32'h0000_0008; idle(1); irq = 32'h0; idle(1);
        wr(3'd2, 4'hF, 32'hFFFF_FFFF); rd(3'd2, "R3");
        // R6 enabled edge delivers a write
        irq = 32'h0000_0020; idle(6); irq = 32'h0; idle(2);
        rd(3'd0, "R4");
        // R9 stalled write, later edges held and issued in turn
        mw_ready = 1'b0;
        irq = 32'h0000_0020; idle(2);
        irq = 32'h0000_0120; idle(1);
        irq = 32'h0; idle(1);
        irq = 32'h0000_0020; idle(5);
        mw_ready = 1'b1; irq = 32'h0; idle(10);
        // R7 control keeps only bit 8
        wr(3'd3, 4'h2, 32'h0000_0100); rd(3'd3, "R7");
        wr(3'd3, 4'hF, 32'hFFFF_FFFF); rd(3'd3, "R7");
        chk("R7", "ctrl read", rdata, 32'h0000_0100);
        // R8 edges during bus error are dropped
        irq = 32'h0000_0020; idle(4); irq = 32'h0; idle(2);
        wr(3'd3, 4'hF, 32'h0); idle(4);
        // R8 queued write waits while bus error is set
        mw_ready = 1'b0;
        irq = 32'h0000_0020; idle(3);
        irq = 32'h0000_0120; idle(1);
        irq = 32'h0;
        wr(3'd3, 4'h2, 32'h0000_0100);
        mw_ready = 1'b1; idle(6);
        wr(3'd3, 4'h2, 32'h0); idle(6);
        // R10 byte writes to the vector, then a delivery with the new payload
        wr(3'd4, 4'h8, 32'hAB00_0000); rd(3'd4, "R10");
        wr(3'd4, 4'h1, 32'h0000_001F); rd(3'd4, "R10");
        chk("R10", "vector bytes", rdata, 32'hAB34_561F);
        irq = 32'h0000_0020; idle(4); irq = 32'h0; idle(2);
        irq = 32'h0400_0000; idle(4); irq = 32'h0; idle(2);
        // R6 unmasking an already-high source is an enabled edge
        irq = 32'h0000_0200; idle(2);
        wr(3'd1, 4'hF, 32'h0000_0200); idle(5);
        irq = 32'h0; idle(3);
        rd(3'd0, "R4"); rd(3'd2, "R2");
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog R9 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule